// File: doc/BRIEF.md
# GPIO Port with Edge Interrupts

This block is a parameterized general-purpose I/O port with one set of controls for each pin. Software reaches it through a simple register interface. Each pin can be set as an output that drives a data bit. It can also be set as an input. An input pin either floats or enables a weak pull-up, and its output-data bit picks which. Every pad value passes through a two-stage synchronizer before it can be read or used for edge detection.

Each input pin can also capture an edge. It has an interrupt enable, a sticky flag and an edge-polarity select. A flag is set on the chosen edge whether or not its enable is set. Software clears a flag by writing zero to it. The block raises one interrupt request whenever any flag is set together with its enable. A parameter mask can mark pin positions as not implemented. Such a pin never drives its pad, reads as zero in every register and ignores every write.

Register map (3-bit address, combinational read): 0 = output data, 1 = sampled input (read only), 2 = direction, 3 = interrupt enable, 4 = interrupt flag, 5 = edge select. Addresses 6 and 7 read zero.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_pu` are all zero and `irq` is low, so every pin starts as a floating input.
- R2: A direction bit of 1 makes the pin an output: `pad_oe` is 1 for that pin and `pad_out` follows the pin's output-data bit.
- R3: A direction bit of 0 makes the pin an input with `pad_oe` at 0. Its output-data bit then selects the pad state: 0 leaves `pad_pu` at 0 (high impedance), and 1 sets `pad_pu` to 1 (weak pull-up).
- R4: The input register (address 1) shows a pad value two clock edges after the change, and still shows the old value after one edge. Writes to address 1 have no effect.
- R5: With edge select 0, a rising edge on an input pin sets its flag and a falling edge does not.
- R6: With edge select 1, a falling edge on an input pin sets its flag and a rising edge does not.
- R7: A flag is set on its selected edge even while its enable is 0. `irq` rises only once the enable for that pin is set.
- R8: Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged.
- R9: When a selected edge and a clearing write to the same flag bit fall in the same cycle, the flag ends up set.
- R10: A pin with direction 1 never sets its flag, whatever its pad does.
- R11: A pin position cleared in the parameter `PIN_MASK` reads 0 in every register, ignores writes, never drives or pulls its pad, and never sets a flag.
- R12: `irq` is the OR over all pins of flag AND enable, and it stays high until the last enabled flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data for `addr` |
| pad_in | input | WIDTH | Raw pad levels, asynchronous |
| pad_oe | output | WIDTH | Output enable for each pad |
| pad_out | output | WIDTH | Value driven when enabled |
| pad_pu | output | WIDTH | Weak pull-up enable for each pad |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: `WIDTH` = 8 and `PIN_MASK` = 8'h7F. The top pin position is therefore absent. This lets the absence rules be checked against a real seven-pin port next to a dead eighth bit: all-ones writes, a toggling pad and reads from every register. It also lets the clear-versus-edge collision be placed on an exact cycle, because the latency of two synchronizer stages plus the edge register is known.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DOUT  = 3'd0,
    REG_DIN   = 3'd1,
    REG_DIR   = 3'd2,
    REG_IEN   = 3'd3,
    REG_FLAG  = 3'd4,
    REG_EDGE  = 3'd5
  } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] sync_q, sync_d;
  logic [WIDTH-1:0] prev_q, prev_d;

  always_comb begin
    meta_d = pad_i;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

  // R4: the delayed copy trails the synchronized value by exactly one edge
  AST_PREV_TRAILS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_q == $past(sync_q))); // R4
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_edge_pkg::*;
#(
  parameter int             WIDTH    = 8,
  parameter logic [WIDTH-1:0] PIN_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  dout_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  ien_o,
  output logic [WIDTH-1:0]  edge_o,
  output logic              flag_wr_o
);
  logic [WIDTH-1:0] dout_q, dout_d;
  logic [WIDTH-1:0] dir_q,  dir_d;
  logic [WIDTH-1:0] ien_q,  ien_d;
  logic [WIDTH-1:0] edge_q, edge_d;
  logic [WIDTH-1:0] wmask;

  assign wmask = wdata & PIN_MASK;

  always_comb begin
    dout_d    = dout_q;
    dir_d     = dir_q;
    ien_d     = ien_q;
    edge_d    = edge_q;
    flag_wr_o = 1'b0;
    if (wr_en) begin
      case (addr)
        REG_DOUT: dout_d    = wmask;
        REG_DIR:  dir_d     = wmask;
        REG_IEN:  ien_d     = wmask;
        REG_EDGE: edge_d    = wmask;
        REG_FLAG: flag_wr_o = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      edge_q <= '0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
      ien_q  <= ien_d;
      edge_q <= edge_d;
    end
  end

  assign dout_o = dout_q;
  assign dir_o  = dir_q;
  assign ien_o  = ien_q;
  assign edge_o = edge_q;

  // R11: absent pin positions never hold a configuration bit
  AST_ABSENT_CFG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((dout_q | dir_q | ien_q | edge_q) & ~PIN_MASK) == '0); // R11
  // R4: a write aimed at the input register leaves the configuration alone
  AST_DIN_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_DIN) |=> ($stable(dout_q) && $stable(dir_q) && $stable(ien_q) && $stable(edge_q))); // R4
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] PIN_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] ien_i,
  input  logic [WIDTH-1:0] edge_sel_i,
  input  logic             flag_wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] flag_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] flag_q, flag_d;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] clr;

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    if (PIN_MASK[p]) begin : g_live
      logic rise_p, fall_p;
      assign rise_p = sync_i[p] & ~prev_i[p];
      assign fall_p = ~sync_i[p] & prev_i[p];
      assign hit[p] = ~dir_i[p] & (edge_sel_i[p] ? fall_p : rise_p);
    end else begin : g_dead
      assign hit[p] = 1'b0;
    end
  end

  assign clr = flag_wr_i ? ~wdata_i : '0;

  always_comb begin
    flag_d = (flag_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ien_i);

  // R10: a newly set flag never belongs to a pin that was an output
  AST_OUTPUT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & $past(dir_i)) == '0)); // R10
  // R8: a flag drops only after a flag-register write
  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_q) & ~flag_q & ~{WIDTH{$past(flag_wr_i)}}) == '0)); // R8
  // R11: absent positions never flag
  AST_ABSENT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~PIN_MASK) == '0); // R11
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] PIN_MASK = 8'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu,
  output logic              irq
);
  logic [WIDTH-1:0] sync_v, prev_v;
  logic [WIDTH-1:0] dout_v, dir_v, ien_v, edge_v, flag_v;
  logic             flag_wr;

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_i(pad_in), .sync_o(sync_v), .prev_o(prev_v)
  );

  gpio_cfg_regs #(.WIDTH(WIDTH), .PIN_MASK(PIN_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dout_o(dout_v), .dir_o(dir_v), .ien_o(ien_v), .edge_o(edge_v),
    .flag_wr_o(flag_wr)
  );

  gpio_edge_flags #(.WIDTH(WIDTH), .PIN_MASK(PIN_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_v), .prev_i(prev_v),
    .dir_i(dir_v), .ien_i(ien_v), .edge_sel_i(edge_v),
    .flag_wr_i(flag_wr), .wdata_i(wdata), .flag_o(flag_v), .irq_o(irq)
  );

  assign pad_oe  = dir_v;
  assign pad_out = dout_v & dir_v;
  assign pad_pu  = dout_v & ~dir_v;

  always_comb begin
    case (addr)
      REG_DOUT: rdata = dout_v;
      REG_DIN:  rdata = sync_v & PIN_MASK;
      REG_DIR:  rdata = dir_v;
      REG_IEN:  rdata = ien_v;
      REG_FLAG: rdata = flag_v;
      REG_EDGE: rdata = edge_v;
      default:  rdata = '0;
    endcase
  end

  // R3: a pad is never driven and pulled up at once
  AST_DRIVE_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0); // R3
  // R12: a request always has an enabled flag behind it
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flag_v & ien_v) != '0)); // R12
  // R11: absent positions never touch the pad
  AST_ABSENT_PAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_pu | pad_out) & ~PIN_MASK) == '0); // R11
endmodule

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;
  localparam int W = 8;
  localparam logic [2:0] A_DOUT = 3'd0, A_DIN = 3'd1, A_DIR = 3'd2,
                         A_IEN = 3'd3, A_FLAG = 3'd4, A_EDGE = 3'd5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = 3'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_oe, pad_out, pad_pu;
  logic         irq;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_port i_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .irq(irq)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 reg %0d after reset", a), v, '0);
    end
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_pu", pad_pu, '0);
    check("R1 irq", {7'd0, irq}, '0);
  endtask

  task automatic t_drive();
    wr(A_DIR, 8'h03);
    wr(A_DOUT, 8'h05);
    check("R2 pad_oe", pad_oe, 8'h03);
    check("R2 pad_out", pad_out, 8'h01);
    check("R3 pull-up on input pin 2", pad_pu, 8'h04);
    wr(A_DOUT, 8'h00);
    check("R3 high impedance", pad_pu | pad_oe & 8'hFC, 8'h00);
    check("R2 pad_out low", pad_out, 8'h00);
    wr(A_DIR, 8'h00);
    check("R3 all inputs", pad_oe, 8'h00);
  endtask

  task automatic t_sync();
    logic [W-1:0] v;
    @(negedge clk);
    pad_in[0] = 1'b1;
    @(negedge clk);
    rd(A_DIN, v);
    check("R4 input after one edge", v, 8'h00);
    @(negedge clk);
    rd(A_DIN, v);
    check("R4 input after two edges", v, 8'h01);
    wr(A_DIN, 8'h00);
    rd(A_DOUT, v);
    check("R4 write to input reg inert", v | pad_oe, 8'h00);
    pad_in[0] = 1'b0;
    settle();
    wr(A_FLAG, 8'h00);
  endtask

  task automatic t_rise();
    logic [W-1:0] v;
    pad_in[1] = 1'b1;
    settle();
    rd(A_FLAG, v);
    check("R5 rising sets flag", v, 8'h02);
    wr(A_FLAG, 8'h00);
    pad_in[1] = 1'b0;
    settle();
    rd(A_FLAG, v);
    check("R5 falling ignored", v, 8'h00);
  endtask

  task automatic t_fall();
    logic [W-1:0] v;
    wr(A_EDGE, 8'h40);
    pad_in[6] = 1'b1;
    settle();
    rd(A_FLAG, v);
    check("R6 rising ignored", v, 8'h00);
    pad_in[6] = 1'b0;
    settle();
    rd(A_FLAG, v);
    check("R6 falling sets flag", v, 8'h40);
    wr(A_FLAG, 8'h00);
    wr(A_EDGE, 8'h00);
  endtask

  task automatic t_enable();
    logic [W-1:0] v;
    pad_in[4] = 1'b1;
    settle();
    rd(A_FLAG, v);
    check("R7 flag set while disabled", v, 8'h10);
    check("R7 irq low while disabled", {7'd0, irq}, 8'h00);
    wr(A_IEN, 8'h10);
    check("R7 irq after enable", {7'd0, irq}, 8'h01);
    wr(A_FLAG, 8'hFF);
    rd(A_FLAG, v);
    check("R8 writing 1 keeps flag", v, 8'h10);
    wr(A_FLAG, 8'hEF);
    rd(A_FLAG, v);
    check("R8 writing 0 clears flag", v, 8'h00);
    check("R8 irq drops", {7'd0, irq}, 8'h00);
    wr(A_IEN, 8'h00);
    pad_in[4] = 1'b0;
    settle();
  endtask

  task automatic t_priority();
    logic [W-1:0] v;
    @(negedge clk);
    pad_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = A_FLAG; wdata = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    rd(A_FLAG, v);
    check("R9 edge wins over clear", v, 8'h08);
    wr(A_FLAG, 8'h00);
    pad_in[3] = 1'b0;
    settle();
  endtask

  task automatic t_outpin();
    logic [W-1:0] v;
    wr(A_DIR, 8'h20);
    pad_in[5] = 1'b1;
    settle();
    pad_in[5] = 1'b0;
    settle();
    rd(A_FLAG, v);
    check("R10 output pin no flag", v, 8'h00);
    wr(A_DIR, 8'h00);
  endtask

  task automatic t_absent();
    logic [W-1:0] v;
    wr(A_DOUT, 8'hFF); wr(A_DIR, 8'hFF); wr(A_IEN, 8'hFF); wr(A_EDGE, 8'hFF);
    rd(A_DOUT, v); check("R11 dout bit7", v, 8'h7F);
    rd(A_DIR, v);  check("R11 dir bit7", v, 8'h7F);
    rd(A_IEN, v);  check("R11 ien bit7", v, 8'h7F);
    rd(A_EDGE, v); check("R11 edge bit7", v, 8'h7F);
    check("R11 pad_oe bit7", pad_oe, 8'h7F);
    wr(A_DIR, 8'h00);
    check("R11 pad_pu bit7", pad_pu, 8'h7F);
    wr(A_EDGE, 8'h00);
    pad_in[7] = 1'b1;
    settle();
    rd(A_DIN, v);  check("R11 input bit7", v, 8'h00);
    rd(A_FLAG, v); check("R11 flag bit7", v, 8'h00);
    check("R11 irq quiet", {7'd0, irq}, 8'h00);
    pad_in[7] = 1'b0;
    wr(A_IEN, 8'h00); wr(A_DOUT, 8'h00);
    settle();
    wr(A_FLAG, 8'h00);
  endtask

  task automatic t_multi();
    wr(A_IEN, 8'h0C);
    pad_in[2] = 1'b1; pad_in[3] = 1'b1;
    settle();
    check("R12 irq two sources", {7'd0, irq}, 8'h01);
    wr(A_FLAG, 8'hFB);
    check("R12 irq one source left", {7'd0, irq}, 8'h01);
    wr(A_FLAG, 8'hF7);
    check("R12 irq all cleared", {7'd0, irq}, 8'h00);
    pad_in[2] = 1'b0; pad_in[3] = 1'b0;
    wr(A_IEN, 8'h00);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drive();
    t_sync();
    t_rise();
    t_fall();
    t_enable();
    t_priority();
    t_outpin();
    t_absent();
    t_multi();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule